// File: doc/BRIEF.md
# Per-Device Wake Trap Power Manager

This block tracks the sleep and wake state of five peripheral slots: three serial ports, one parallel port and one floppy controller. Every slot owns a trap bit and an idle timer. Activity that belongs to that class of device sets the slot's trap bit and reloads its idle timer. When the timer runs out, the bit drops and the slot's power-down output rises. The real peripherals are not part of the block. Their activity arrives on event inputs: host accesses, interrupts, DMA acknowledges, start-bit strobes, modem and parallel status lines, and the motor field of floppy digital-output writes.

A global state machine sits above the slots. While it is sleeping, any slot event whose resume-enable bit is set raises a global wake flag and moves the machine to working. A standby timer is reloaded as long as any trap bit is set. Once every trap bit has been clear for the standby period, the machine returns to sleeping and drops the wake flag. Software sees all of this in one 8-bit status register. A bit clears when software writes a 1 to it. Idle and standby timers count prescaled ticks.

Top module: `wake_trap_pm`

## Requirements
- R1: The status register reads bit 7 = global wake flag, bit 6 = third serial trap, bit 3 = parallel trap, bit 2 = floppy trap, bit 1 = first serial trap, bit 0 = second serial trap, and bits 5:4 always read 0. After reset the register reads 0x00, `pwr_down_o` is all ones and `working_o` is 0.
- R2: On a register write, each implemented bit written with 1 is cleared. Bits written with 0 and writes to bits 5:4 have no effect.
- R3: The wake flag is set only when the machine is sleeping and a slot event occurs whose `wake_en_i` bit is set (bit 0 second serial, 1 first serial, 2 floppy, 3 parallel, 4 third serial). Setting the flag also makes `working_o` 1. A slot event with its enable clear sets only the trap bit.
- R4: A serial slot's trap bit is set by that port's access, IRQ, receiver start-bit or transmitter start-bit strobe, or by a change in either direction on any of its four modem lines. A modem line held at a steady level does not set it. Ports are indexed 0 = first, 1 = second, 2 = third.
- R5: The parallel trap bit is set by a parallel access, IRQ, DMA acknowledge, or a change in either direction on any of the five status lines.
- R6: The floppy trap bit is set by a floppy access, IRQ, DMA acknowledge, or a digital-output write whose 4-bit motor field turns on a motor that the previous write left off. The motor shadow resets to 0.
- R7: A trap bit becomes visible one clock edge after its event, and the event reloads the slot's idle count. After that many prescaled ticks without a further event, the trap bit clears and the slot's `pwr_down_o` bit goes to 1. Slot order of `pwr_down_o` is the same as `wake_en_i`.
- R8: When a hardware set and a software write-1 clear of the same bit fall in the same cycle, the bit ends up 1.
- R9: While working, the standby timer reloads whenever any trap bit is set. Once all trap bits have stayed clear for the standby count of ticks, `working_o` falls and the wake flag clears.
- R10: A software clear of the wake flag leaves `working_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Status register write strobe |
| reg_wdata_i | input | 8 | Write data, 1 clears the bit |
| reg_rdata_o | output | 8 | Status register read value |
| wake_en_i | input | 5 | Per-slot resume enable |
| ser_access_i | input | 3 | Serial host access strobes |
| ser_irq_i | input | 3 | Serial interrupt requests |
| ser_rx_start_i | input | 3 | Receiver start-bit detected |
| ser_tx_start_i | input | 3 | Transmitter shifter sending start bit |
| ser_modem_i | input | 3x4 | Modem control input levels per port |
| par_access_i | input | 1 | Parallel host access strobe |
| par_irq_i | input | 1 | Parallel interrupt request |
| par_dack_i | input | 1 | Parallel DMA acknowledge |
| par_status_i | input | 5 | Parallel status line levels |
| fdc_access_i | input | 1 | Floppy host access strobe |
| fdc_irq_i | input | 1 | Floppy interrupt request |
| fdc_dack_i | input | 1 | Floppy DMA acknowledge |
| fdc_dor_we_i | input | 1 | Digital-output register write strobe |
| fdc_motor_wdata_i | input | 4 | Motor field of that write |
| pwr_down_o | output | 5 | Per-slot power-down request |
| working_o | output | 1 | Global state machine is working |

## Verification
Most internal faults in this block show up in the status register one edge after the stimulus. A missed or misrouted event leaves a trap bit clear, or sets the wrong bit position. A bad edge detector sets a bit under a steady line. A lost set-over-clear priority clears a bit that should stay set. Timer faults only appear at expiry, so the bench brackets each expiry between the last tick that must not end it and the tick that must. A prescaler or reload fault therefore moves a transition outside a window one tick period wide. A wrong global state shows as a wake flag that rises while working or while the slot's enable is clear, or as `working_o` falling too early or too late.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned NUM_SLOTS = 5;
  localparam int unsigned NUM_SER   = 3;
  localparam int unsigned SLOT_FDC  = 2;
  localparam int unsigned SLOT_PAR  = 3;

  typedef enum logic {PM_SLEEP, PM_WORK} pm_state_e;

  // status register bit of a slot
  function automatic int unsigned slot_bit(int unsigned s);
    return (s == 4) ? 6 : s;
  endfunction

  // slot fed by serial port s
  function automatic int unsigned ser_slot(int unsigned s);
    return (s == 0) ? 1 : (s == 1) ? 0 : 4;
  endfunction
endpackage

// File: rtl/pm_tick.sv
module pm_tick #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pm_slot.sv
module pm_slot #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned PRESET = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wake_i,
  input  logic clr_i,
  output logic trap_o
);
  logic             trap_q;
  logic [TMR_W-1:0] cnt_q;

  assign trap_o = trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wake_i) begin
      trap_q <= 1'b1;
      cnt_q  <= TMR_W'(PRESET);
    end else if (clr_i) begin
      trap_q <= 1'b0;
    end else if (tick_i && trap_q) begin
      if (cnt_q <= TMR_W'(1)) begin
        trap_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r7_wake_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> trap_q && cnt_q == TMR_W'(PRESET));
  a_r8_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i && clr_i |=> trap_q);
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !wake_i |=> !trap_q);
  a_r7_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q && !tick_i && !clr_i |=> trap_q);
endmodule

// File: rtl/pm_standby.sv
module pm_standby #(
  parameter int unsigned TMR_W = 8,
  parameter int unsigned STBY  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic resume_i,
  input  logic any_trap_i,
  input  logic flag_clr_i,
  output logic flag_o,
  output logic working_o
);
  import pm_pkg::*;

  pm_state_e        state_q;
  logic             flag_q;
  logic [TMR_W-1:0] cnt_q;

  assign flag_o    = flag_q;
  assign working_o = (state_q == PM_WORK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_SLEEP;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (state_q == PM_SLEEP) begin
      if (resume_i) begin
        state_q <= PM_WORK;
        flag_q  <= 1'b1;
        cnt_q   <= TMR_W'(STBY);
      end
    end else begin
      if (flag_clr_i) flag_q <= 1'b0;
      if (any_trap_i) begin
        cnt_q <= TMR_W'(STBY);
      end else if (tick_i) begin
        if (cnt_q <= TMR_W'(1)) begin
          state_q <= PM_SLEEP;
          flag_q  <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  a_r3_flag_from_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(state_q) == PM_SLEEP);
  a_r3_resume_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_SLEEP && resume_i |=> flag_q && state_q == PM_WORK);
  a_r9_trap_holds_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_WORK && any_trap_i |=> state_q == PM_WORK);
  a_r9_sleep_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_SLEEP |-> !flag_q);
  a_r10_clear_keeps_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PM_WORK && flag_clr_i && any_trap_i |=> state_q == PM_WORK);
endmodule

// File: rtl/wake_trap_pm.sv
module wake_trap_pm #(
  parameter int unsigned PRESCALE = 4,
  parameter int unsigned TMR_W    = 8,
  parameter int unsigned IDLE_SER = 20,
  parameter int unsigned IDLE_PAR = 24,
  parameter int unsigned IDLE_FDC = 22,
  parameter int unsigned STBY     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [4:0]       wake_en_i,
  input  logic [2:0]       ser_access_i,
  input  logic [2:0]       ser_irq_i,
  input  logic [2:0]       ser_rx_start_i,
  input  logic [2:0]       ser_tx_start_i,
  input  logic [2:0][3:0]  ser_modem_i,
  input  logic             par_access_i,
  input  logic             par_irq_i,
  input  logic             par_dack_i,
  input  logic [4:0]       par_status_i,
  input  logic             fdc_access_i,
  input  logic             fdc_irq_i,
  input  logic             fdc_dack_i,
  input  logic             fdc_dor_we_i,
  input  logic [3:0]       fdc_motor_wdata_i,
  output logic [4:0]       pwr_down_o,
  output logic             working_o
);
  import pm_pkg::*;

  logic [2:0][3:0]       modem_q;
  logic [4:0]            par_st_q;
  logic [3:0]            motor_q;
  logic [NUM_SER-1:0]    ser_ev;
  logic                  par_ev, fdc_ev;
  logic [NUM_SLOTS-1:0]  ev, clr, trap;
  logic                  tick, flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      modem_q  <= '0;
      par_st_q <= '0;
      motor_q  <= '0;
    end else begin
      modem_q  <= ser_modem_i;
      par_st_q <= par_status_i;
      if (fdc_dor_we_i) motor_q <= fdc_motor_wdata_i;
    end
  end

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser_ev
    assign ser_ev[s] = ser_access_i[s] | ser_irq_i[s] | ser_rx_start_i[s]
                     | ser_tx_start_i[s] | (|(ser_modem_i[s] ^ modem_q[s]));
  end

  assign par_ev = par_access_i | par_irq_i | par_dack_i | (|(par_status_i ^ par_st_q));
  // only motors turning on count
  assign fdc_ev = fdc_access_i | fdc_irq_i | fdc_dack_i
                | (fdc_dor_we_i & |(fdc_motor_wdata_i & ~motor_q));

  always_comb begin
    ev = '0;
    for (int s = 0; s < NUM_SER; s++) ev[ser_slot(s)] = ser_ev[s];
    ev[SLOT_FDC] = fdc_ev;
    ev[SLOT_PAR] = par_ev;
  end

  pm_tick #(.PRESCALE(PRESCALE)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int unsigned PRE = (i == SLOT_FDC) ? IDLE_FDC :
                                  (i == SLOT_PAR) ? IDLE_PAR : IDLE_SER;
    assign clr[i] = reg_we_i & reg_wdata_i[slot_bit(i)];
    pm_slot #(.TMR_W(TMR_W), .PRESET(PRE)) i_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .wake_i(ev[i]),
      .clr_i (clr[i]),
      .trap_o(trap[i])
    );
  end

  pm_standby #(.TMR_W(TMR_W), .STBY(STBY)) i_standby (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .resume_i  (|(ev & wake_en_i)),
    .any_trap_i(|trap),
    .flag_clr_i(reg_we_i & reg_wdata_i[7]),
    .flag_o    (flag),
    .working_o (working_o)
  );

  always_comb begin
    reg_rdata_o    = '0;
    reg_rdata_o[7] = flag;
    for (int i = 0; i < NUM_SLOTS; i++) reg_rdata_o[slot_bit(i)] = trap[i];
  end

  assign pwr_down_o = ~trap;

  a_r2_zero_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_wdata_i == 8'h00 && ev == '0 && !tick |=> $stable(reg_rdata_o));
  a_r4_steady_modem_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap[ser_slot(2)] && $stable(ser_modem_i) && ser_access_i == '0 && ser_irq_i == '0
    && ser_rx_start_i == '0 && ser_tx_start_i == '0 |=> !reg_rdata_o[6]);
endmodule

// File: tb/test_wake_trap_pm.sv
`timescale 1ns/1ps
module test_wake_trap_pm;
  localparam int unsigned P   = 4;
  localparam int unsigned ISR = 20;
  localparam int unsigned STB = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [7:0]       reg_wdata_i = '0;
  logic [7:0]       reg_rdata_o;
  logic [4:0]       wake_en_i = '0;
  logic [2:0]       ser_access_i = '0, ser_irq_i = '0, ser_rx_start_i = '0, ser_tx_start_i = '0;
  logic [2:0][3:0]  ser_modem_i = '0;
  logic             par_access_i = 0, par_irq_i = 0, par_dack_i = 0;
  logic [4:0]       par_status_i = '0;
  logic             fdc_access_i = 0, fdc_irq_i = 0, fdc_dack_i = 0, fdc_dor_we_i = 0;
  logic [3:0]       fdc_motor_wdata_i = '0;
  logic [4:0]       pwr_down_o;
  logic             working_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  wake_trap_pm #(.PRESCALE(P), .TMR_W(8), .IDLE_SER(ISR), .IDLE_PAR(24),
                 .IDLE_FDC(22), .STBY(STB)) i_wake_trap_pm (.*);

  // {event code, write enable, write data, expected status}
  localparam logic [20:0] VEC [0:8] = '{
    {4'd1, 1'b0, 8'h00, 8'h82},  // R4 first serial access, R3 wake
    {4'd2, 1'b0, 8'h00, 8'h83},  // R4 second serial rx start
    {4'd3, 1'b0, 8'h00, 8'hC3},  // R4 third serial modem rise
    {4'd4, 1'b0, 8'h00, 8'hCB},  // R5 status line rise
    {4'd5, 1'b0, 8'h00, 8'hCF},  // R6 motor on
    {4'd0, 1'b1, 8'h30, 8'hCF},  // R2 reserved write
    {4'd0, 1'b1, 8'h00, 8'hCF},  // R2 zero write
    {4'd0, 1'b1, 8'h81, 8'h4E},  // R2 clear flag and bit 0
    {4'd0, 1'b1, 8'h4E, 8'h00}   // R2 clear the rest
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    reg_we_i = 0; ser_access_i = '0; ser_irq_i = '0; ser_rx_start_i = '0;
    ser_tx_start_i = '0; par_access_i = 0; par_irq_i = 0; par_dack_i = 0;
    fdc_access_i = 0; fdc_irq_i = 0; fdc_dack_i = 0; fdc_dor_we_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    clear_pulses();
  endtask

  task automatic apply_ev(int code);
    case (code)
      1: ser_access_i[0] = 1;
      2: ser_rx_start_i[1] = 1;
      3: ser_modem_i[2][0] = ~ser_modem_i[2][0];
      4: par_status_i[2] = ~par_status_i[2];
      5: begin fdc_dor_we_i = 1; fdc_motor_wdata_i = 4'b0010; end
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] d);
    reg_we_i = 1; reg_wdata_i = d;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    check("R1 reset status", reg_rdata_o, 8'h00);
    check("R1 reset pwr_down", {3'b0, pwr_down_o}, 8'h1F);
    check("R1 reset working", {7'b0, working_o}, 8'h00);

    wake_en_i = 5'h1F;
    for (int v = 0; v < 9; v++) begin
      apply_ev(int'(VEC[v][20:17]));
      if (VEC[v][16]) wr(VEC[v][15:8]);
      step();
      check($sformatf("R1/R2 vector %0d", v), reg_rdata_o, VEC[v][7:0]);
    end
    check("R10 still working after flag clear", {7'b0, working_o}, 8'h01);

    // R9: standby window measured from the clearing write
    repeat ((STB - 1) * P) step();
    check("R9 working before standby expiry", {7'b0, working_o}, 8'h01);
    repeat (P) step();
    check("R9 sleeping after standby expiry", {7'b0, working_o}, 8'h00);

    // R3: disabled resume
    wake_en_i = 5'h00;
    par_access_i = 1; step();
    check("R3 disabled event status", reg_rdata_o, 8'h08);
    check("R3 disabled event stays asleep", {7'b0, working_o}, 8'h00);
    wake_en_i = 5'h1F;
    fdc_irq_i = 1; step();
    check("R3 enabled event status", reg_rdata_o, 8'h8C);
    check("R3 enabled event working", {7'b0, working_o}, 8'h01);

    // R8: set and clear together
    par_irq_i = 1; wr(8'h08); step();
    check("R8 set beats clear", reg_rdata_o, 8'h8C);

    wr(8'h8C); step();
    check("R2 clear all", reg_rdata_o, 8'h00);
    check("R10 working after flag clear", {7'b0, working_o}, 8'h01);

    // R6: motor field edges
    fdc_dor_we_i = 1; fdc_motor_wdata_i = 4'b0010; step();
    check("R6 motor already on", reg_rdata_o, 8'h00);
    fdc_dor_we_i = 1; fdc_motor_wdata_i = 4'b0000; step();
    check("R6 motor off", reg_rdata_o, 8'h00);
    fdc_dor_we_i = 1; fdc_motor_wdata_i = 4'b0010; step();
    check("R6 motor turned on", reg_rdata_o, 8'h04);

    // R4: steady modem high, then fall
    check("R4 steady modem line", reg_rdata_o & 8'h40, 8'h00);
    ser_modem_i[2][0] = 1'b0; step();
    check("R4 modem fall", reg_rdata_o & 8'h40, 8'h40);

    // R5: status fall and DMA acknowledge
    par_status_i[2] = 1'b0; step();
    check("R5 status fall", reg_rdata_o & 8'h08, 8'h08);
    wr(8'h08); step();
    par_dack_i = 1; step();
    check("R5 dma ack", reg_rdata_o & 8'h08, 8'h08);

    // R7: idle expiry window on the first serial slot
    wr(8'hCF); step();
    check("R7 all clear before timing", reg_rdata_o, 8'h00);
    ser_tx_start_i[0] = 1; step();
    repeat ((ISR - 1) * P) step();
    check("R7 trap held before expiry", reg_rdata_o & 8'h02, 8'h02);
    check("R7 powered before expiry", {7'b0, pwr_down_o[1]}, 8'h00);
    repeat (P) step();
    check("R7 trap cleared at expiry", reg_rdata_o & 8'h02, 8'h00);
    check("R7 power-down at expiry", {7'b0, pwr_down_o[1]}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule